// File: doc/BRIEF.md
# Twiddled Texture Address Generator

This block turns a texel coordinate into the byte offset of that texel inside a power-of-two texture stored in interleaved ("twiddled") order. Coordinate bits of the two axes are woven together so that small squares of texels land close to each other in memory. When the texture is not square, interleaving stops once the shorter axis runs out of bits. The remaining bits of the longer axis are then stacked above the woven part.

For mipmapped textures, the block treats the texture as square and addresses one selected level. It adds that level's start offset from the top of the mip chain. There are two layouts: plain texels, whose offsets scale with the pixel depth, and vector-quantised data, where one index byte covers a 2x2 texel block. The result is registered once and travels with a valid flag. A caller adds it to the texture base address.

Top module: `twiddle_addr`

## Requirements
- R1: For each bit position i below the size of both axes, bit i of v goes to texel-index bit 2i and bit i of u goes to bit 2i+1.
- R2: When one axis is longer, its bits from position m upward go consecutively into index bits 2m, 2m+1, ... Here m is the bit count of the shorter axis.
- R3: Coordinate bits at or above log2 of that axis's size have no effect on the offset.
- R4: Without mipmapping, the width is 8 << wcode and the height is 8 << hcode.
- R5: With mip_on=1, hcode is ignored. Both axes of the addressed level have log2 size mip_lvl, where level 0 is 1x1 and level 10 is 1024x1024. mip_lvl is clamped to wcode+3.
- R6: With vq_on=1, the offset is the level base plus the texel index shifted right by 2. The level base is 0 when mipmapping is off. By level from 0 to 10, the bases are 0x0, 0x1, 0x2, 0x6, 0x16, 0x56, 0x156, 0x556, 0x1556, 0x5556 and 0x15556 bytes.
- R7: With vq_on=0, the offset is (base*bpp)/8 + (index*bpp)/8, with each term truncated. The texel base is 0 without mipmapping. Otherwise it is 3 for level 0 and 3 + (4^L - 1)/3 for level L. bpp_sel codes are 0 for 4, 1 for 8, and 2 or 3 for 16 bits per pixel.
- R8: out_valid equals in_valid of the previous cycle. out_offset loads the result one cycle after a valid input and holds its value after a cycle with in_valid=0.
- R9: While rst_n is low and after reset, out_valid is 0 and out_offset is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| u_coord | input | 10 | Horizontal texel coordinate |
| v_coord | input | 10 | Vertical texel coordinate |
| wcode | input | 3 | Width code, width = 8 << wcode |
| hcode | input | 3 | Height code, height = 8 << hcode |
| mip_on | input | 1 | Mipmapped square texture |
| mip_lvl | input | 4 | Addressed level, log2 of its side |
| vq_on | input | 1 | Vector-quantised layout |
| bpp_sel | input | 2 | Pixel depth code |
| out_valid | output | 1 | Result present |
| out_offset | output | 23 | Byte offset from texture base |

## Verification
Every cycle, the assertions check the valid pipeline and that the offset holds when no request arrived. They also check that an 8x8 texture at 8 bits per pixel stays under 64 bytes, and that level 0 lands on its fixed base in both layouts. The bit ordering for square, wide and tall shapes, the ignoring of high coordinate bits, the mip-level clamp and the depth scaling can only be shown by the bench's scenarios. There, each result is compared against a behavioural model of the interleave.

// File: rtl/twiddle_addr.sv
module twiddle_addr #(
  parameter int CW = 10,
  parameter int OW = 23
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [CW-1:0] u_coord,
  input  logic [CW-1:0] v_coord,
  input  logic [2:0]    wcode,
  input  logic [2:0]    hcode,
  input  logic          mip_on,
  input  logic [3:0]    mip_lvl,
  input  logic          vq_on,
  input  logic [1:0]    bpp_sel,
  output logic          out_valid,
  output logic [OW-1:0] out_offset
);
  localparam int IW = 2 * CW;

  logic [3:0]    wlog, hlog, lvl_eff, lw, lh, lmin;
  logic [IW-1:0] idx;
  logic [OW-1:0] pat_l, pat_lm1, vq_base, tx_base, tx_base_b, idx_b, result;

  assign wlog    = {1'b0, wcode} + 4'd3;
  assign hlog    = {1'b0, hcode} + 4'd3;
  assign lvl_eff = (mip_lvl > wlog) ? wlog : mip_lvl;
  assign lw      = mip_on ? lvl_eff : wlog;
  assign lh      = mip_on ? lvl_eff : hlog;
  assign lmin    = (lw < lh) ? lw : lh;

  always_comb begin
    idx = '0;
    for (int i = 0; i < CW; i++) begin
      if (i < int'(lmin)) begin
        idx[2*i]   = v_coord[i];
        idx[2*i+1] = u_coord[i];
      end else if (lw > lh && i < int'(lw)) begin
        idx[int'(lmin)+i] = u_coord[i];
      end else if (lh > lw && i < int'(lh)) begin
        idx[int'(lmin)+i] = v_coord[i];
      end
    end
  end

  always_comb begin
    pat_l   = '0;
    pat_lm1 = '0;
    for (int k = 0; k < CW + 1; k++) begin
      if (k < int'(lvl_eff))       pat_l[2*k]   = 1'b1;
      if (k + 1 < int'(lvl_eff))   pat_lm1[2*k] = 1'b1;
    end
  end

  assign vq_base = !mip_on ? '0 : (lvl_eff == 4'd0) ? '0 : pat_lm1 + OW'(1);
  assign tx_base = !mip_on ? '0 : pat_l + OW'(3);

  always_comb begin
    case (bpp_sel)
      2'd0:    begin tx_base_b = tx_base >> 1; idx_b = OW'(idx >> 1); end
      2'd1:    begin tx_base_b = tx_base;      idx_b = OW'(idx);      end
      default: begin tx_base_b = tx_base << 1; idx_b = OW'(idx) << 1; end
    endcase
  end

  assign result = vq_on ? vq_base + OW'(idx >> 2) : tx_base_b + idx_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_offset <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_offset <= result;
    end
  end

  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));
  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_offset));
  a_r4_small_square_range: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mip_on && !vq_on && bpp_sel == 2'd1 && wcode == 3'd0 && hcode == 3'd0)
    |=> (out_offset < OW'(64)));
  a_r7_level0_base: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mip_on && !vq_on && bpp_sel == 2'd1 && mip_lvl == 4'd0)
    |=> (out_offset == OW'(3)));
  a_r6_level0_vq: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mip_on && vq_on && mip_lvl == 4'd0) |=> (out_offset == '0));
  a_r9_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && out_offset == '0));
endmodule

// File: tb/test_twiddle_addr.sv
module test_twiddle_addr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [9:0]  u_coord = '0, v_coord = '0;
  logic [2:0]  wcode = '0, hcode = '0;
  logic        mip_on = 1'b0, vq_on = 1'b0;
  logic [3:0]  mip_lvl = '0;
  logic [1:0]  bpp_sel = '0;
  logic        out_valid;
  logic [22:0] out_offset;

  int checks = 0, errors = 0;
  int exp_off = 0;
  bit exp_val = 0;
  string exp_tag = "R9";

  always #10 clk = ~clk;

  twiddle_addr i_twiddle_addr (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .u_coord(u_coord), .v_coord(v_coord),
    .wcode(wcode), .hcode(hcode), .mip_on(mip_on), .mip_lvl(mip_lvl), .vq_on(vq_on),
    .bpp_sel(bpp_sel), .out_valid(out_valid), .out_offset(out_offset));

  function automatic int model(int u, int v, int wc, int hc, bit mip, int lvl, bit vq, int bs);
    int sw, sh, bpp, idx, sh_pos, base;
    sw = 8 << wc; sh = 8 << hc;
    if (mip) begin
      if (lvl > wc + 3) lvl = wc + 3;
      sw = 1 << lvl; sh = sw;
    end
    idx = 0; sh_pos = 0; sw = sw >> 1; sh = sh >> 1;
    while (sw != 0 || sh != 0) begin
      if (sh != 0) begin idx |= (v & 1) << sh_pos; v >>= 1; sh >>= 1; sh_pos++; end
      if (sw != 0) begin idx |= (u & 1) << sh_pos; u >>= 1; sw >>= 1; sh_pos++; end
    end
    bpp = (bs == 0) ? 4 : (bs == 1) ? 8 : 16;
    if (vq) begin
      base = 0;
      if (mip) for (int l = 1; l <= lvl; l++) base += (l == 1) ? 1 : (1 << (2 * (l - 2)));
      return base + idx / 4;
    end
    base = 0;
    if (mip) begin
      base = 3;
      for (int l = 1; l <= lvl; l++) base += 1 << (2 * (l - 1));
    end
    return (base * bpp) / 8 + (idx * bpp) / 8;
  endfunction

  task automatic check_now();
    checks++;
    if (out_valid !== exp_val || (exp_val && out_offset !== 23'(exp_off))) begin
      errors++;
      $display("FAIL %s: valid=%0b offset=%h expected valid=%0b offset=%h",
               exp_tag, out_valid, out_offset, exp_val, 23'(exp_off));
    end
  endtask

  task automatic req(string tag, int u, int v, int wc, int hc, bit mip, int lvl, bit vq, int bs);
    @(negedge clk);
    check_now();
    in_valid = 1'b1; u_coord = 10'(u); v_coord = 10'(v); wcode = 3'(wc); hcode = 3'(hc);
    mip_on = mip; mip_lvl = 4'(lvl); vq_on = vq; bpp_sel = 2'(bs);
    exp_off = model(u & 1023, v & 1023, wc, hc, mip, lvl, vq, bs);
    exp_val = 1; exp_tag = tag;
  endtask

  task automatic idle(string tag);
    @(negedge clk);
    check_now();
    in_valid = 1'b0; u_coord = ~u_coord; v_coord = ~v_coord; wcode = ~wcode; bpp_sel = ~bpp_sel;
    exp_val = 0; exp_tag = tag;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_offset !== '0) begin
      errors++;
      $display("FAIL R9: valid=%0b offset=%h expected 0/0", out_valid, out_offset);
    end
    rst_n = 1'b1;
    // R1 square interleave
    req("R1", 1, 0, 0, 0, 0, 0, 0, 1);
    req("R1", 0, 1, 0, 0, 0, 0, 0, 1);
    req("R1", 7, 5, 0, 0, 0, 0, 0, 1);
    req("R1", 300, 700, 7, 7, 0, 0, 0, 2);
    // R2 non-square: wide then tall
    req("R2", 255, 3, 5, 0, 0, 0, 0, 1);
    req("R2", 2, 1000, 0, 7, 0, 0, 0, 1);
    req("R2", 513, 6, 7, 1, 0, 0, 0, 2);
    // R3 high bits ignored
    req("R3", 1023, 1023, 0, 0, 0, 0, 0, 1);
    req("R3", 1016, 0, 0, 2, 0, 0, 0, 1);
    // R4 size codes
    for (int c = 0; c < 8; c++) req("R4", 1023, 511, c, 7 - c, 0, 0, 0, 1);
    // R5 mipmap: hcode ignored, clamp
    req("R5", 3, 2, 2, 0, 1, 2, 0, 1);
    req("R5", 3, 2, 2, 7, 1, 2, 0, 1);
    req("R5", 60, 33, 0, 5, 1, 15, 0, 1);
    // R6 VQ bases, every level
    for (int l = 0; l <= 10; l++) req("R6", 1023, 1023, 7, 3, 1, l, 1, 1);
    req("R6", 77, 200, 4, 6, 0, 0, 1, 0);
    // R7 depth scaling, every level and depth
    for (int b = 0; b < 4; b++)
      for (int l = 0; l <= 10; l++) req("R7", 5 * l, 3 * l + 1, 7, 0, 1, l, 0, b);
    req("R7", 9, 3, 1, 1, 0, 0, 0, 0);
    // R8 hold on idle cycles
    req("R8", 5, 6, 1, 1, 0, 0, 0, 1);
    idle("R8");
    idle("R8");
    req("R8", 2, 1, 1, 1, 0, 0, 0, 2);
    // mixed patterns
    for (int n = 0; n < 400; n++)
      req("R2", int'($urandom_range(0, 1023)), int'($urandom_range(0, 1023)),
          int'($urandom_range(0, 7)), int'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
          int'($urandom_range(0, 15)), 1'($urandom_range(0, 1)), int'($urandom_range(0, 3)));
    idle("R8");
    @(negedge clk);
    check_now();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule